// File: doc/BRIEF.md
# Programmable Terminal-Count Timer

This block is a 14-bit down-counting timer whose count is advanced by an external timer-clock input rather than by the system clock. That input passes through a two-flop synchroniser and a rising-edge detector in the system clock domain. Each detected rising edge moves the count down by one while the timer is running. A dedicated output pin reports the terminal-count behaviour. Depending on the mode, that output is either a square wave across the count or a single low timer-clock pulse at terminal count.

A host sets up the timer through a small register interface with chip select, write strobe, read strobe and a 2-bit register address. The host writes a count length and a 2-bit mode, then issues start and stop commands. The mode selects two things: whether the timer stops at terminal count or reloads itself and keeps running, and whether the output is a square wave or a pulse. The host can read back the live count, the mode, and a status word. The status word carries a terminal-count flag that clears when it is read.

Register layout (address: write / read):
- 0: count length in `wdata[13:0]` / live count.
- 1: command, where `wdata[0]` = start and `wdata[1]` = stop / status, where bit0 = terminal-count flag and bit1 = running.
- 2: mode in `wdata[1:0]` / mode.
- 3: no effect on write / reads as zero.

Top module: `tc_timer`

## Requirements
- R1: After reset the live count reads 0, the status reads 0 (flag clear, not running) and `tc_out` is high.
- R2: A command write with bit0 set loads the live count with the effective count length and starts the timer, whether it was idle or running; the load is visible at the first read after the write cycle.
- R3: While running, the live count drops by exactly one for each rising edge of `tmr_clk`, detected after a two-flop synchroniser. Edges arriving while the timer is not running leave the count unchanged.
- R4: Terminal count is the detected edge that finds the count at 1. In one-shot mode (mode bit0 = 0) that edge sets the count to 0 and stops the timer. Later edges do nothing until the next start command.
- R5: In continuous mode (mode bit0 = 1), the terminal-count edge reloads the effective count length and the timer keeps running with no host action.
- R6: In square-wave mode (mode bit1 = 0) with effective length L, `tc_out` is high while running and the count is greater than floor(L/2), and low otherwise while running. For odd L the high part is one timer clock longer than the low part.
- R7: In pulse mode (mode bit1 = 1), `tc_out` is low only while running with the count at 1, which is exactly one timer-clock period ending at terminal count. It is high at all other times.
- R8: A written count length of 0 or 1 behaves as a length of 2.
- R9: A command write with bit1 set stops the timer and freezes the count; stop takes precedence over start in the same write. While stopped, `tc_out` is high.
- R10: The status flag (bit0 at address 1) is set by every terminal-count event and cleared by a read strobe to address 1. A set in the same cycle as the read wins.
- R11: The mode register at address 2 uses this encoding: 00 one-shot square, 01 continuous square, 10 one-shot pulse, 11 continuous pulse. It reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_clk | input | 1 | External timer clock, asynchronous |
| cs | input | 1 | Register interface select |
| wr | input | 1 | Write strobe, qualified by cs |
| rd | input | 1 | Read strobe, qualified by cs (clears status flag at address 1) |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the addressed register |
| tc_out | output | 1 | Terminal-count output pin |

## Verification
Several properties are checked on every cycle by the assertions. These are:
- the single-cycle edge pulse;
- the one-step decrement;
- the hold while idle;
- the one-shot stop and the continuous reload at terminal count;
- the minimum effective length;
- the flag being set by each terminal-count event.

Some behaviours can only be shown by the bench's sweeps, which step every length from 0 to 9 in all four modes and compare against an arithmetic model. These are the exact square-wave split for odd and even lengths, the pulse position, the read-to-clear flag timing, stop-over-start precedence, and the full 14-bit length.

// File: rtl/tct_pkg.sv
package tct_pkg;
  // Mode field: bit0 selects reload, bit1 selects pulse output.
  typedef struct packed {
    logic pulse;
    logic cont;
  } tct_mode_t;

  localparam logic [1:0] REG_LEN  = 2'd0;
  localparam logic [1:0] REG_CTL  = 2'd1;
  localparam logic [1:0] REG_MODE = 2'd2;

  localparam int CMD_START_BIT = 0;
  localparam int CMD_STOP_BIT  = 1;
endpackage

// File: rtl/tct_sync.sv
module tct_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [2:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[1:0], async_in};
  end

  // sh_q[0], sh_q[1] form the synchroniser, sh_q[2] is the edge history
  assign rise = sh_q[1] & ~sh_q[2];

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R3
endmodule

// File: rtl/tct_regs.sv
module tct_regs
  import tct_pkg::*;
#(
  parameter int CNT_W = 14,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs,
  input  logic             wr,
  input  logic             rd,
  input  logic [1:0]       addr,
  input  logic [DW-1:0]    wdata,
  input  logic [CNT_W-1:0] cnt,
  input  logic             running,
  input  logic             tc_evt,
  output logic [CNT_W-1:0] len_q,
  output tct_mode_t        mode_q,
  output logic             start_p,
  output logic             stop_p,
  output logic [DW-1:0]    rdata
);
  logic flag_q;
  logic wr_en, rd_status;

  assign wr_en     = cs & wr;
  assign rd_status = cs & rd & (addr == REG_CTL);
  assign stop_p    = wr_en & (addr == REG_CTL) & wdata[CMD_STOP_BIT];
  assign start_p   = wr_en & (addr == REG_CTL) & wdata[CMD_START_BIT] & ~stop_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      mode_q <= '0;
    end else if (wr_en) begin
      if (addr == REG_LEN)  len_q  <= wdata[CNT_W-1:0];
      if (addr == REG_MODE) mode_q <= wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag_q <= 1'b0;
    else if (tc_evt)    flag_q <= 1'b1;
    else if (rd_status) flag_q <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      REG_LEN:  rdata[CNT_W-1:0] = cnt;
      REG_CTL:  rdata[1:0]       = {running, flag_q};
      REG_MODE: rdata[1:0]       = mode_q;
      default:  rdata            = '0;
    endcase
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    tc_evt |=> flag_q); // R10
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status && !tc_evt |=> !flag_q); // R10
endmodule

// File: rtl/tct_counter.sv
module tct_counter
  import tct_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start_p,
  input  logic             stop_p,
  input  logic [CNT_W-1:0] len_q,
  input  tct_mode_t        mode_q,
  output logic [CNT_W-1:0] cnt,
  output logic             running,
  output logic             tc_evt,
  output logic             tc_out
);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] MINL  = CNT_W'(2);

  function automatic logic [CNT_W-1:0] eff_len(input logic [CNT_W-1:0] l);
    return (l < MINL) ? MINL : l;
  endfunction

  function automatic logic sq_high(input logic [CNT_W-1:0] c,
                                   input logic [CNT_W-1:0] l);
    return c > (l >> 1);
  endfunction

  logic [CNT_W-1:0] act_len;
  logic             step;

  assign step   = running & tick & ~start_p & ~stop_p;
  assign tc_evt = step & (cnt == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
      act_len <= MINL;
    end else if (stop_p) begin
      running <= 1'b0;
    end else if (start_p) begin
      act_len <= eff_len(len_q);
      cnt     <= eff_len(len_q);
      running <= 1'b1;
    end else if (tc_evt) begin
      if (mode_q.cont) begin
        cnt <= act_len;
      end else begin
        cnt     <= '0;
        running <= 1'b0;
      end
    end else if (step) begin
      cnt <= cnt - ONE;
    end
  end

  always_comb begin
    if (!running)         tc_out = 1'b1;
    else if (mode_q.pulse) tc_out = (cnt != ONE);
    else                  tc_out = sq_high(cnt, act_len);
  end

  AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    step && cnt > ONE |=> cnt == $past(cnt) - ONE); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !start_p |=> $stable(cnt) && !running); // R9
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    tc_evt && !mode_q.cont |=> !running && cnt == '0); // R4
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    tc_evt && mode_q.cont |=> running && cnt == act_len); // R5
  AST_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> running && cnt >= MINL); // R8
  AST_RUN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> cnt != '0 && cnt <= act_len); // R2
endmodule

// File: rtl/tc_timer.sv
module tc_timer
  import tct_pkg::*;
#(
  parameter int CNT_W = 14,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tmr_clk,
  input  logic          cs,
  input  logic          wr,
  input  logic          rd,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          tc_out
);
  logic             tick;
  logic [CNT_W-1:0] len_q;
  tct_mode_t        mode_q;
  logic             start_p, stop_p;
  logic [CNT_W-1:0] cnt;
  logic             running, tc_evt;

  tct_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (tmr_clk),
    .rise     (tick)
  );

  tct_regs #(.CNT_W(CNT_W), .DW(DW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs      (cs),
    .wr      (wr),
    .rd      (rd),
    .addr    (addr),
    .wdata   (wdata),
    .cnt     (cnt),
    .running (running),
    .tc_evt  (tc_evt),
    .len_q   (len_q),
    .mode_q  (mode_q),
    .start_p (start_p),
    .stop_p  (stop_p),
    .rdata   (rdata)
  );

  tct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .start_p (start_p),
    .stop_p  (stop_p),
    .len_q   (len_q),
    .mode_q  (mode_q),
    .cnt     (cnt),
    .running (running),
    .tc_evt  (tc_evt),
    .tc_out  (tc_out)
  );

  AST_PULSE_ONLY_AT_TC: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q.pulse && !tc_out |-> running && cnt == CNT_W'(1)); // R7
endmodule

// File: tb/test_tc_timer.sv
module test_tc_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tmr_clk = 1'b0;
  logic        cs = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        tc_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tc_timer i_tc_timer (
    .clk(clk), .rst_n(rst_n), .tmr_clk(tmr_clk), .cs(cs), .wr(wr), .rd(rd),
    .addr(addr), .wdata(wdata), .rdata(rdata), .tc_out(tc_out)
  );

  // bench model
  int m_cnt, m_len;
  bit m_run, m_cont, m_pulse, m_tc;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk);
    cs = 0; wr = 0; wdata = '0;
  endtask

  task automatic rd_reg(input logic [1:0] a, input bit strobe, output int v);
    @(negedge clk);
    cs = 1; rd = strobe; addr = a;
    #1 v = int'(rdata);
    @(negedge clk);
    cs = 0; rd = 0;
  endtask

  task automatic timer_edge();
    @(negedge clk); tmr_clk = 1;
    repeat (4) @(negedge clk);
    tmr_clk = 0;
    repeat (4) @(negedge clk);
    m_tc = 0;
    if (m_run) begin
      if (m_cnt == 1) begin
        m_tc = 1;
        if (m_cont) m_cnt = m_len;
        else begin m_cnt = 0; m_run = 0; end
      end else m_cnt = m_cnt - 1;
    end
  endtask

  function automatic int exp_out();
    if (!m_run) return 1;
    if (m_pulse) return (m_cnt == 1) ? 0 : 1;
    // high for the first ceil(L/2) positions of the count
    return ((m_len - m_cnt) < (m_len + 1) / 2) ? 1 : 0;
  endfunction

  task automatic start_run(input int len, input int mode);
    int v;
    wr_reg(2'd0, 16'(len));
    wr_reg(2'd2, 16'(mode));
    rd_reg(2'd1, 1, v);
    wr_reg(2'd1, 16'h1);
    m_len = (len < 2) ? 2 : len;
    m_cnt = m_len; m_run = 1;
    m_cont = mode[0]; m_pulse = mode[1];
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd_reg(2'd0, 0, v); check("R1 count after reset", v, 0);
    rd_reg(2'd1, 1, v); check("R1 status after reset", v, 0);
    check("R1 tc_out after reset", int'(tc_out), 1);
    // R3 edges while idle do nothing
    m_run = 0; m_cnt = 0;
    timer_edge();
    rd_reg(2'd0, 0, v); check("R3 idle edge ignored", v, 0);

    for (int mode = 0; mode < 4; mode++) begin
      for (int len = 0; len < 10; len++) begin
        start_run(len, mode);
        rd_reg(2'd2, 0, v); check("R11 mode readback", v, mode);
        rd_reg(2'd0, 0, v); check("R2 R8 start load", v, m_len);
        check("R6 R7 out after start", int'(tc_out), exp_out());
        for (int k = 0; k < 2 * m_len + 2; k++) begin
          timer_edge();
          rd_reg(2'd0, 0, v);
          check(m_cont ? "R5 R3 count continuous" : "R4 R3 count one-shot", v, m_cnt);
          check(m_pulse ? "R7 pulse output" : "R6 square output", int'(tc_out), exp_out());
          rd_reg(2'd1, 1, v);
          check("R10 status flag", v & 1, int'(m_tc));
          check("R4 R5 running bit", (v >> 1) & 1, int'(m_run));
        end
      end
    end

    // R9 stop freezes, output high; stop wins over start
    start_run(7, 1);
    repeat (3) timer_edge();
    wr_reg(2'd1, 16'h2); m_run = 0;
    rd_reg(2'd0, 0, v); check("R9 frozen count", v, 4);
    check("R9 tc_out high when stopped", int'(tc_out), 1);
    timer_edge(); timer_edge();
    rd_reg(2'd0, 0, v); check("R9 frozen after edges", v, 4);
    wr_reg(2'd1, 16'h3);
    rd_reg(2'd1, 0, v); check("R9 stop beats start", (v >> 1) & 1, 0);
    rd_reg(2'd0, 0, v); check("R9 count kept", v, 4);
    // R2 restart while running reloads
    start_run(7, 1);
    timer_edge(); timer_edge();
    wr_reg(2'd1, 16'h1);
    rd_reg(2'd0, 0, v); check("R2 restart reload", v, 7);
    // R2 full 14-bit length
    start_run(16383, 0);
    rd_reg(2'd0, 0, v); check("R2 max length", v, 16383);
    timer_edge();
    rd_reg(2'd0, 0, v); check("R3 max length step", v, 16382);
    check("R6 max length high", int'(tc_out), 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule